// File: doc/BRIEF.md
# Analog Monitor Command Register Block

This block is a bus-attached register slave. It stands between a processor and the register file of an on-chip analog monitor. Software sets up a configuration word, an interrupt mask and a master control word. It then issues commands by writing one 32-bit word to a command port. Each command reads one 16-bit monitor register, writes one, or does nothing, and every accepted command completes in the cycle it is written.

Results come back through a 16-entry read-data queue, and they arrive one command late. An accepted command first queues the result of the command before it. It then keeps its own result until the next command arrives. Software therefore issues one extra command, usually a no-op, to flush out the last result. A level interrupt shows any unmasked status bit. One of those bits reports that the queue holds more entries than a programmable threshold. The monitor register file is a 128-entry by 16-bit storage array inside the block.

Top module: `amon_cmd_regs`

## Requirements
- R1: After reset, the registers read as follows: configuration 0x0000_1814, interrupt status 0x0000_0200, interrupt mask 0xFFFF_FFFF, master control 0x0000_0010, status 0x0000_0500. The queue is empty, all monitor registers are 0 and the held result is 0.
- R2: The word offset on `bus_addr` selects the register: 0 configuration, 1 interrupt status, 2 interrupt mask, 3 status (read only), 4 command port (write only), 5 read queue (read only), 6 master control. A read of offset 4 or of offsets 7 to 15 returns 0. A write to offset 3, offset 5 or offsets 7 to 15 changes nothing.
- R3: A command word carries its opcode in bits 29:26 (0 no-op, 1 read, 2 write), the monitor register address in bits 25:16 and the write data in bits 15:0. Opcodes 3 to 15 are dropped with no effect.
- R4: An accepted command queues the held result if the queue holds fewer than 16 entries, and then holds its own result. When the queue is full the old held result is lost and the count stays at 16.
- R5: The result of a read command is the addressed monitor register. The result of a write or a no-op is 0. A write command stores bits 15:0 into the addressed monitor register.
- R6: A command is dropped while master control bit 4 is 1. It is also dropped when its opcode is not a no-op and its address is 128 or higher.
- R7: A write to interrupt status clears each bit written as 1. Bit 9 (command queue below threshold) is set again in the same cycle, so it always reads 1.
- R8: A write to the interrupt mask stores only bits 9:0. `irq` is 1 exactly when some interrupt status bit in 9:0 is 1 while its mask bit is 0.
- R9: Interrupt status bit 8 is set whenever, after the cycle's operation, the queue count is strictly greater than configuration bits 19:16. It stays set until it is cleared by a write.
- R10: A status read returns the queue count in bits 16:12, 1 in bit 10, "queue full" in bit 9, "queue empty" in bit 8 and 0 in all other bits.
- R11: A read of offset 5 returns the oldest queue entry in bits 15:0 and removes it. A read of an empty queue returns 0 and the count stays 0.
- R12: A write to master control stores the written value ANDed with 0x00FF_FEFF. A configuration write stores all 32 bits.
- R13: `bus_rdata` holds the value of a read on the clock edge after the request. In every other cycle it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_valid | input | 1 | Request strobe, one access per cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt, unmasked status present |

## Verification
Every register, queue and status update takes effect on the edge that samples the request. `irq` is driven by those registers only, so it shows the new state from that same edge, and read data becomes visible after that edge too. The bench drives each request half a cycle ahead of the edge. It advances a behavioural model at the edge and compares `bus_rdata` and `irq` with the model at the following falling edge. It repeats that comparison on every idle cycle, where the read data must be 0.

// File: rtl/amon_pkg.sv
package amon_pkg;

    localparam int BUS_W   = 32;
    localparam int OFF_W   = 4;
    localparam int MON_W   = 16;
    localparam int INT_W   = 10;

    // register word offsets (decoded by software, order fixed)
    localparam logic [OFF_W-1:0] OFF_CFG   = 4'd0;
    localparam logic [OFF_W-1:0] OFF_ISTS  = 4'd1;
    localparam logic [OFF_W-1:0] OFF_IMASK = 4'd2;
    localparam logic [OFF_W-1:0] OFF_STAT  = 4'd3;
    localparam logic [OFF_W-1:0] OFF_CMD   = 4'd4;
    localparam logic [OFF_W-1:0] OFF_RDQ   = 4'd5;
    localparam logic [OFF_W-1:0] OFF_MCTL  = 4'd6;

    typedef enum logic [3:0] {
        OP_NOP   = 4'd0,
        OP_READ  = 4'd1,
        OP_WRITE = 4'd2
    } op_e;

    typedef struct packed {
        logic [1:0]  rsvd;
        logic [3:0]  op;
        logic [9:0]  addr;
        logic [15:0] data;
    } cmd_t;

    typedef struct packed {
        logic            accept;
        logic            is_read;
        logic            is_write;
        logic [9:0]      addr;
        logic [MON_W-1:0] data;
    } cmd_dec_t;

    localparam logic [BUS_W-1:0] CFG_RST    = 32'h0000_1814;
    localparam logic [INT_W-1:0] ISTS_RST   = 10'h200;
    localparam logic [INT_W-1:0] IMASK_RST  = 10'h3FF;
    localparam logic [BUS_W-1:0] MCTL_RST   = 32'h0000_0010;
    localparam logic [BUS_W-1:0] MCTL_WMASK = 32'h00FF_FEFF;

    localparam int MCTL_HOLD_BIT = 4;
    localparam int INT_LTH_BIT   = 9;
    localparam int INT_GTH_BIT   = 8;
    localparam int THR_LSB       = 16;
    localparam int THR_W         = 4;

    function automatic logic [THR_W-1:0] cfg_thresh(input logic [BUS_W-1:0] cfg);
        return cfg[THR_LSB +: THR_W];
    endfunction

endpackage

// File: rtl/amon_cmd_dec.sv
module amon_cmd_dec
    import amon_pkg::*;
#(
    parameter int MON_REGS = 128
) (
    input  logic [BUS_W-1:0] word,
    input  logic             hold,
    input  logic             strobe,
    output cmd_dec_t         dec
);
    cmd_t cmd;
    logic in_range;
    logic op_known;

    assign cmd      = cmd_t'(word);
    assign in_range = int'(cmd.addr) < MON_REGS;
    assign op_known = (cmd.op == OP_NOP) || (cmd.op == OP_READ) || (cmd.op == OP_WRITE);

    always_comb begin
        dec          = '0;
        dec.addr     = cmd.addr;
        dec.data     = cmd.data;
        dec.accept   = strobe && !hold && op_known &&
                       ((cmd.op == OP_NOP) || in_range);
        dec.is_read  = dec.accept && (cmd.op == OP_READ);
        dec.is_write = dec.accept && (cmd.op == OP_WRITE);
    end
endmodule

// File: rtl/amon_monram.sv
module amon_monram #(
    parameter int ENTRIES = 128,
    parameter int WIDTH   = 16,
    localparam int AW     = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
        end else if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/amon_rdfifo.sv
module amon_rdfifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 16,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] pop_data,
    output logic [CW-1:0]    count,
    output logic [CW-1:0]    count_nx,
    output logic             full,
    output logic             empty
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wp_q, rp_q;
    logic [CW-1:0]    cnt_q;
    logic             do_push, do_pop;

    assign full     = (cnt_q == CW'(DEPTH));
    assign empty    = (cnt_q == '0);
    assign do_push  = push && !full;
    assign do_pop   = pop && !empty;
    assign pop_data = empty ? '0 : mem[rp_q];
    assign count    = cnt_q;

    always_comb begin
        count_nx = cnt_q;
        case ({do_push, do_pop})
            2'b10:   count_nx = cnt_q + 1'b1;
            2'b01:   count_nx = cnt_q - 1'b1;
            default: count_nx = cnt_q;
        endcase
    end

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) begin
                mem[wp_q] <= push_data;
                wp_q      <= bump(wp_q);
            end
            if (do_pop) rp_q <= bump(rp_q);
            cnt_q <= count_nx;
        end
    end

    AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(DEPTH)) else $error("fifo count above depth"); // R4

    AST_FIFO_FULL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (push && !pop && full) |=> (cnt_q == CW'(DEPTH))) else $error("full push changed count"); // R4

    AST_FIFO_EMPTY_POP: assert property (@(posedge clk) disable iff (rst)
        (pop && !push && empty) |=> (cnt_q == '0)) else $error("empty pop changed count"); // R11
endmodule

// File: rtl/amon_cmd_regs.sv
module amon_cmd_regs
    import amon_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int MON_REGS   = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [OFF_W-1:0]  bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              irq
);
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
    localparam int RA_W  = $clog2(MON_REGS);

    logic [BUS_W-1:0] cfg_q, cfg_nx, mctl_q, rdata_q, rd_val, stat_val;
    logic [INT_W-1:0] ists_q, ists_nx, imask_q, ists_clr;
    logic [MON_W-1:0] held_q, mon_rd, q_out;
    logic [CNT_W-1:0] q_cnt, q_cnt_nx;
    logic             q_full, q_empty;
    logic             wr, rd, gth;
    cmd_dec_t         dec;

    assign wr = bus_valid && bus_write;
    assign rd = bus_valid && !bus_write;

    amon_cmd_dec #(.MON_REGS(MON_REGS)) u_dec (
        .word   (bus_wdata),
        .hold   (mctl_q[MCTL_HOLD_BIT]),
        .strobe (wr && bus_addr == OFF_CMD),
        .dec    (dec)
    );

    amon_monram #(.ENTRIES(MON_REGS), .WIDTH(MON_W)) u_ram (
        .clk   (clk),
        .rst   (rst),
        .we    (dec.is_write),
        .addr  (dec.addr[RA_W-1:0]),
        .wdata (dec.data),
        .rdata (mon_rd)
    );

    amon_rdfifo #(.DEPTH(FIFO_DEPTH), .WIDTH(MON_W)) u_rdq (
        .clk       (clk),
        .rst       (rst),
        .push      (dec.accept),
        .push_data (held_q),
        .pop       (rd && bus_addr == OFF_RDQ),
        .pop_data  (q_out),
        .count     (q_cnt),
        .count_nx  (q_cnt_nx),
        .full      (q_full),
        .empty     (q_empty)
    );

    // interrupt status next state, evaluated on post-operation values
    assign cfg_nx   = (wr && bus_addr == OFF_CFG) ? bus_wdata : cfg_q;
    assign ists_clr = (wr && bus_addr == OFF_ISTS) ? bus_wdata[INT_W-1:0] : '0;
    assign gth      = q_cnt_nx > CNT_W'(cfg_thresh(cfg_nx));

    always_comb begin
        ists_nx = ists_q & ~ists_clr;
        ists_nx[INT_LTH_BIT] = 1'b1;
        if (gth) ists_nx[INT_GTH_BIT] = 1'b1;
    end

    always_comb begin
        stat_val = '0;
        stat_val[12 +: CNT_W] = q_cnt;
        stat_val[10] = 1'b1;
        stat_val[9]  = q_full;
        stat_val[8]  = q_empty;
    end

    always_comb begin
        case (bus_addr)
            OFF_CFG:   rd_val = cfg_q;
            OFF_ISTS:  rd_val = BUS_W'(ists_q);
            OFF_IMASK: rd_val = {{(BUS_W-INT_W){imask_q == IMASK_RST && mask_all_q}}, imask_q};
            OFF_STAT:  rd_val = stat_val;
            OFF_RDQ:   rd_val = BUS_W'(q_out);
            OFF_MCTL:  rd_val = mctl_q;
            default:   rd_val = '0;
        endcase
    end

    // the mask reads all ones until software first writes it
    logic mask_all_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q      <= CFG_RST;
            ists_q     <= ISTS_RST;
            imask_q    <= IMASK_RST;
            mask_all_q <= 1'b1;
            mctl_q     <= MCTL_RST;
            held_q     <= '0;
            rdata_q    <= '0;
        end else begin
            cfg_q   <= cfg_nx;
            ists_q  <= ists_nx;
            rdata_q <= rd ? rd_val : '0;
            if (wr && bus_addr == OFF_IMASK) begin
                imask_q    <= bus_wdata[INT_W-1:0];
                mask_all_q <= 1'b0;
            end
            if (wr && bus_addr == OFF_MCTL) mctl_q <= bus_wdata & MCTL_WMASK;
            if (dec.accept) held_q <= dec.is_read ? mon_rd : '0;
        end
    end

    assign bus_rdata = rdata_q;
    assign irq       = |(ists_q & ~imask_q);

    AST_LTH_ALWAYS_SET: assert property (@(posedge clk) disable iff (rst)
        ists_q[INT_LTH_BIT]) else $error("bit 9 of status cleared"); // R7

    AST_HOLD_DROPS_CMD: assert property (@(posedge clk) disable iff (rst)
        (wr && bus_addr == OFF_CMD && mctl_q[MCTL_HOLD_BIT]) |=> $stable(q_cnt))
        else $error("command accepted while held"); // R6

    AST_BAD_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd && (bus_addr == OFF_CMD || bus_addr > OFF_MCTL)) |=> (bus_rdata == '0))
        else $error("rejected read returned data"); // R2

    AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (rst)
        !rd |=> (bus_rdata == '0)) else $error("read data outside a read"); // R13
endmodule

// File: tb/amon_cmd_regs_tb.sv
module amon_cmd_regs_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    amon_cmd_regs u_dut (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference model
    logic [31:0] m_cfg, m_mask, m_mctl;
    logic [9:0]  m_ists;
    logic [15:0] m_mon [128];
    logic [15:0] m_held;
    logic [15:0] m_q [$];

    task automatic model_reset();
        m_cfg = 32'h1814; m_ists = 10'h200; m_mask = 32'hFFFF_FFFF;
        m_mctl = 32'h10; m_held = '0; m_q.delete();
        for (int i = 0; i < 128; i++) m_mon[i] = '0;
    endtask

    task automatic model_ints();
        m_ists[9] = 1'b1;
        if (m_q.size() > int'(m_cfg[19:16])) m_ists[8] = 1'b1;
    endtask

    function automatic logic model_irq();
        return |(m_ists & ~m_mask[9:0]);
    endfunction

    task automatic model_cmd(input logic [31:0] w);
        int op, ra;
        op = int'(w[29:26]);
        ra = int'(w[25:16]);
        if (m_mctl[4]) return;
        if (op > 2) return;
        if (op != 0 && ra >= 128) return;
        if (m_q.size() < 16) m_q.push_back(m_held);
        if (op == 1) m_held = m_mon[ra];
        else begin
            if (op == 2) m_mon[ra] = w[15:0];
            m_held = '0;
        end
    endtask

    function automatic logic [31:0] model_read(input int a);
        logic [31:0] v;
        int n;
        n = m_q.size();
        case (a)
            0: v = m_cfg;
            1: v = 32'(m_ists);
            2: v = m_mask;
            3: v = (32'(n) << 12) | 32'h400 | ((n == 16) ? 32'h200 : 32'h0) | ((n == 0) ? 32'h100 : 32'h0);
            5: v = (n == 0) ? 32'h0 : 32'(m_q.pop_front());
            6: v = m_mctl;
            default: v = '0;
        endcase
        return v;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic op(input bit w, input int a, input logic [31:0] d, input string tag);
        logic [31:0] exp;
        exp = '0;
        bus_valid = 1'b1; bus_write = w; bus_addr = 4'(a); bus_wdata = d;
        @(posedge clk);
        if (w) begin
            case (a)
                0: m_cfg = d;
                1: m_ists = m_ists & ~d[9:0];
                2: m_mask = {22'b0, d[9:0]};
                4: model_cmd(d);
                6: m_mctl = d & 32'h00FF_FEFF;
                default: ;
            endcase
        end else begin
            exp = model_read(a);
        end
        model_ints();
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
        check({tag, " rdata"}, bus_rdata, exp);
        check({tag, " irq"}, 32'(irq), 32'(model_irq()));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            check("R13 idle rdata", bus_rdata, 32'h0);
            check("R8 idle irq", 32'(irq), 32'(model_irq()));
        end
    endtask

    function automatic logic [31:0] cmdw(input int opc, input int ra, input int dat);
        return {2'b00, 4'(opc), 10'(ra), 16'(dat)};
    endfunction

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1 irq after reset", 32'(irq), 32'h0);
        op(0, 0, 0, "R1 cfg reset");
        op(0, 1, 0, "R1 ists reset");
        op(0, 2, 0, "R1 mask reset");
        op(0, 6, 0, "R1 mctl reset");
        op(0, 3, 0, "R1 R10 status reset");
        // R6: commands dropped while held
        op(1, 4, cmdw(2, 5, 16'hAAAA), "R6 held write");
        op(0, 3, 0, "R6 count after held cmd");
        op(1, 6, 32'hFFFF_FFFF, "R12 mctl write");
        op(0, 6, 0, "R12 mctl readback");
        op(1, 6, 32'h0, "R12 release hold");
        op(1, 2, 32'hFFFF_FEFF, "R8 mask write");
        op(0, 2, 0, "R8 mask readback");
        // R5 R4: writes then lagged reads
        op(1, 4, cmdw(2, 5, 16'h1234), "R5 write reg5");
        op(1, 4, cmdw(2, 127, 16'hBEEF), "R5 write reg127");
        op(1, 4, cmdw(1, 5, 0), "R4 read reg5");
        op(1, 4, cmdw(1, 127, 0), "R4 read reg127");
        op(1, 4, cmdw(0, 900, 0), "R3 nop flush");
        op(0, 3, 0, "R10 status level");
        for (int i = 0; i < 5; i++) op(0, 5, 0, "R11 pop");
        op(0, 5, 0, "R11 pop empty");
        op(0, 3, 0, "R11 count stays 0");
        // R6 out of range, R3 bad opcode
        op(1, 4, cmdw(1, 128, 0), "R6 range read");
        op(1, 4, cmdw(2, 600, 16'h5555), "R6 range write");
        op(1, 4, cmdw(3, 5, 0), "R3 opcode 3");
        op(1, 4, cmdw(15, 5, 0), "R3 opcode 15");
        op(0, 3, 0, "R3 R6 nothing queued");
        // R2 access rules
        op(1, 3, 32'hFFFF_FFFF, "R2 write status");
        op(1, 5, 32'hFFFF_FFFF, "R2 write rdq");
        op(1, 9, 32'hFFFF_FFFF, "R2 write offset9");
        op(0, 4, 0, "R2 read cmd port");
        op(0, 7, 0, "R2 read offset7");
        op(0, 15, 0, "R2 read offset15");
        op(0, 0, 0, "R2 cfg unchanged");
        // R9 threshold interrupt
        op(1, 0, 32'h0002_1814, "R9 set threshold 2");
        op(1, 4, cmdw(1, 127, 0), "R9 cmd a");
        op(1, 4, cmdw(1, 5, 0), "R9 cmd b");
        op(0, 1, 0, "R9 below threshold");
        op(1, 4, cmdw(0, 0, 0), "R9 cmd c");
        op(0, 1, 0, "R9 above threshold");
        idle(2);
        op(0, 5, 0, "R9 pop keeps sticky");
        op(1, 1, 32'h0000_0300, "R7 clear bits");
        op(0, 1, 0, "R7 bit9 back, bit8 cleared");
        // R4 fill beyond full
        for (int i = 0; i < 20; i++) op(1, 4, cmdw(2, i, 16'h100 + i), "R4 fill");
        op(0, 3, 0, "R10 status full");
        for (int i = 0; i < 17; i++) op(0, 5, 0, "R11 drain");
        op(1, 1, 32'h3FF, "R7 clear all");
        op(0, 1, 0, "R7 only bit9");
        op(1, 2, 32'h0, "R8 unmask all");
        idle(2);
        op(1, 6, 32'h10, "R6 hold again");
        op(1, 4, cmdw(0, 0, 0), "R6 nop while held");
        op(0, 3, 0, "R6 queue empty");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule